// File: doc/BRIEF.md
# Read/Write Bus Direction Arbiter

This block sits in front of a memory controller's burst scheduler and decides, slot by slot, whether the shared data bus serves reads or writes. It looks only at how full the read queue and the write queue are, plus a strobe that marks each burst actually issued. It drives the current direction and a ready flag that the scheduler must see high before it issues a burst.

Writes are held back and drained in batches. The arbiter switches to writes in two cases: the write queue crosses a high fill mark, or the read queue is empty while the write queue is at least at a low fill mark. Once it has switched, it stays on writes for a minimum number of issued bursts before it goes back to reads, unless the write queue runs dry. Every change of direction starts a bus turnaround penalty, and the two directions have different lengths. For the whole penalty the ready flag is low and the direction is frozen. The fill marks are given as percentages of the write queue depth and are turned into entry counts, rounded up, when the design is elaborated.

Top module: `rw_dir_arbiter`

## Requirements
- R1: After reset the direction output is 0 (reads) and the ready output is 1.
- R2: In read mode with ready high, a write occupancy at or above the high mark switches the direction to 1 (writes) at the next clock edge, whatever the read occupancy.
- R3: In read mode with ready high, an empty read queue together with a write occupancy at or above the low mark switches to writes. With a non-empty read queue, or with write occupancy below the low mark, the direction stays on reads (absent R2).
- R4: After a read-to-write switch, ready is low for exactly RTW_CYC cycles (default 2) and then returns high.
- R5: After a write-to-read switch, ready is low for exactly WTR_CYC cycles (default 6) and then returns high.
- R6: In write mode, fewer than MIN_WR (default 16) counted bursts since the switch keep the direction on writes while the write queue is non-empty.
- R7: In write mode with ready high, an empty write queue returns the direction to reads at the next edge, regardless of the burst count.
- R8: Once the minimum is met, the direction returns to reads only when the read queue is non-empty and write occupancy is below the low mark. Otherwise it stays on writes.
- R9: While ready is low, the direction does not change and burst strobes are not counted toward the minimum.
- R10: With defaults (64-entry write queue, 85 % and 50 %), the high mark is 55 entries and the low mark is 32 entries. Both are rounded up from the percentages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cnt | input | $clog2(RQ_DEPTH+1) | Read queue occupancy |
| wr_cnt | input | $clog2(WQ_DEPTH+1) | Write queue occupancy |
| burst_done | input | 1 | One burst issued this cycle in the current direction |
| wr_dir | output | 1 | Bus direction: 0 reads, 1 writes |
| grant_rdy | output | 1 | High when a burst may be issued (no turnaround pending) |

## Verification
The bench probes each fill mark one entry below and at the mark. A design that rounds down, or that compares with the wrong sign, switches one entry early or late. The bench also counts the exact length of both turnaround windows, so a penalty that is off by one, or that uses the length of the other direction, stands out. It asserts burst strobes and a high write fill during a turnaround. A design that counts those strobes returns to reads one burst too early, and one that decides during the penalty flips direction while ready is low. Finally, it separates the return conditions: reads waiting, write fill below the low mark, and an empty write queue. This exposes a design that ignores the minimum, or that waits out the minimum when the write queue has emptied.

// File: rtl/rw_dir_arbiter.sv
module rw_dir_arbiter #(
  parameter int WQ_DEPTH = 64,
  parameter int RQ_DEPTH = 32,
  parameter int HI_PCT   = 85,
  parameter int LO_PCT   = 50,
  parameter int MIN_WR   = 16,
  parameter int WTR_CYC  = 6,
  parameter int RTW_CYC  = 2,
  localparam int RCW = $clog2(RQ_DEPTH + 1),
  localparam int WCW = $clog2(WQ_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RCW-1:0] rd_cnt,
  input  logic [WCW-1:0] wr_cnt,
  input  logic           burst_done,
  output logic           wr_dir,
  output logic           grant_rdy
);

  localparam int HI_TH = (WQ_DEPTH * HI_PCT + 99) / 100;
  localparam int LO_TH = (WQ_DEPTH * LO_PCT + 99) / 100;
  localparam int TMAX  = (WTR_CYC > RTW_CYC) ? WTR_CYC : RTW_CYC;
  localparam int TW    = $clog2(TMAX + 2);
  localparam int MCW   = $clog2(MIN_WR + 2);

  logic [TW-1:0]  turn;
  logic [MCW-1:0] wcnt;

  wire idle   = (turn == '0);
  wire at_hi  = ({1'b0, wr_cnt} >= (WCW+1)'(HI_TH));
  wire at_lo  = ({1'b0, wr_cnt} >= (WCW+1)'(LO_TH));
  wire rd_mt  = (rd_cnt == '0);
  wire wr_mt  = (wr_cnt == '0);
  wire min_ok = (wcnt >= MCW'(MIN_WR));

  wire go_wr = !wr_dir && idle && (at_hi || (rd_mt && at_lo));
  wire go_rd = wr_dir && idle && (wr_mt || (min_ok && !rd_mt && !at_lo));

  assign grant_rdy = idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_dir <= 1'b0;
      turn   <= '0;
      wcnt   <= '0;
    end else if (go_wr) begin
      wr_dir <= 1'b1;
      turn   <= TW'(RTW_CYC);
      wcnt   <= '0;
    end else if (go_rd) begin
      wr_dir <= 1'b0;
      turn   <= TW'(WTR_CYC);
      wcnt   <= '0;
    end else if (!idle) begin
      turn <= turn - 1'b1;
    end else if (wr_dir && burst_done && !min_ok) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  p_force_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_dir && grant_rdy && at_hi) |=> wr_dir);

  p_min_writes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && grant_rdy && !min_ok && !wr_mt) |=> wr_dir);

  p_empty_waiver_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && grant_rdy && wr_mt) |=> !wr_dir);

  p_frozen_turn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_rdy |=> (wr_dir == $past(wr_dir)));

  p_turn_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    turn <= TW'(TMAX));

  generate
    if (RTW_CYC > 0) begin : g_rtw_chk
      p_rtw_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_dir) |-> !grant_rdy);
    end
    if (WTR_CYC > 0) begin : g_wtr_chk
      p_wtr_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_dir) |-> !grant_rdy);
    end
  endgenerate

endmodule

// File: tb/sim_rw_dir_arbiter.sv
module sim_rw_dir_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] rd_cnt = '0;
  logic [6:0] wr_cnt = '0;
  logic burst_done = 1'b0;
  logic wr_dir, grant_rdy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic d; logic r; string tag; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  rw_dir_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt),
    .burst_done(burst_done), .wr_dir(wr_dir), .grant_rdy(grant_rdy)
  );

  task automatic step(input int rd, input int wr, input bit bs,
                      input bit ed, input bit er, input string tag);
    exp_t e;
    @(negedge clk);
    rd_cnt = 6'(rd);
    wr_cnt = 7'(wr);
    burst_done = bs;
    e.d = ed; e.r = er; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic rep(input int n, input int rd, input int wr, input bit bs,
                     input bit ed, input bit er, input string tag);
    for (int i = 0; i < n; i++) step(rd, wr, bs, ed, er, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (wr_dir !== e.d || grant_rdy !== e.r) begin
        errors++;
        $display("FAIL %s: dir=%b rdy=%b expected dir=%b rdy=%b",
                 e.tag, wr_dir, grant_rdy, e.d, e.r);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (wr_dir !== 1'b0 || grant_rdy !== 1'b1) begin
      errors++;
      $display("FAIL R1: dir=%b rdy=%b expected dir=0 rdy=1", wr_dir, grant_rdy);
    end
    // R2 / R10: high mark at 55, not 54
    step(5, 54, 0, 0, 1, "R2 R10 below high mark");
    step(5, 55, 0, 1, 0, "R2 force write at high mark");
    // R4 + R9: strobe during turnaround is ignored
    step(5, 55, 1, 1, 0, "R4 rtw penalty");
    step(5, 20, 0, 1, 1, "R4 rtw end");
    // R6: 15 counted bursts, 16th keeps write (would flip if strobe above counted)
    rep(15, 5, 20, 1, 1, 1, "R6 R9 min writes pending");
    step(5, 20, 1, 1, 1, "R9 16th burst still write");
    step(5, 20, 0, 0, 0, "R6 return after minimum");
    // R5 + R9: high fill during wtr penalty has no effect
    rep(5, 5, 60, 0, 0, 0, "R5 R9 wtr penalty frozen");
    step(5, 60, 0, 0, 1, "R5 wtr end");
    step(5, 60, 0, 1, 0, "R2 force after penalty");
    step(0, 40, 0, 1, 0, "R4 rtw penalty");
    step(0, 40, 0, 1, 1, "R4 rtw end");
    // R8: minimum met but no reads / fill too high
    rep(16, 0, 40, 1, 1, 1, "R8 bursts");
    step(0, 20, 0, 1, 1, "R8 reads empty stays write");
    step(3, 40, 0, 1, 1, "R8 above low mark stays write");
    step(3, 31, 0, 0, 0, "R8 return to read");
    rep(5, 3, 31, 0, 0, 0, "R5 wtr penalty");
    step(3, 31, 0, 0, 1, "R5 wtr end");
    // R3 / R10: low mark at 32, only with reads empty
    step(0, 31, 0, 0, 1, "R3 R10 below low mark");
    step(1, 40, 0, 0, 1, "R3 reads pending stays read");
    step(0, 32, 0, 1, 0, "R3 enter write at low mark");
    step(0, 32, 0, 1, 0, "R4 rtw penalty");
    step(0, 32, 0, 1, 1, "R4 rtw end");
    // R7: empty write queue waives minimum
    step(4, 0, 0, 0, 0, "R7 empty waiver");
    rep(5, 4, 0, 0, 0, 0, "R5 wtr penalty");
    step(4, 0, 0, 0, 1, "R5 wtr end");
    step(4, 0, 0, 0, 1, "R3 idle read");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule